// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two eight-bit ports, A and B, and holds one storage register for each direction. Each port has separate input, output and output-enable signals instead of a tri-state pin. An external pad or bus model combines them. One register follows the A side and is clocked by `clk_ab`. The other follows the B side and is clocked by `clk_ba`. On every rising edge of its own clock, a register loads the resolved value of the bus it watches. That load happens whatever the enables are set to.

Each output port takes its data from one of two sources, chosen by a per-direction select. The first source is the live value from the opposite port's external input. The second is the stored register of that direction. Two enables of opposite polarity decide which ports drive. Port B drives when `en_b` is high, and port A drives when `en_a_n` is low, so both ports can drive at once. The live path always uses the opposite port's external input and never the block's own output. This keeps every enable and select setting free of a combinational loop.

The control pins are plain level signals. No data stream passes through this block, so it has no valid/ready handshake and no back-pressure. A synchronous `rst`, sampled by each clock, clears that clock's register.

Top module: `dual_reg_xcvr`

## Requirements
- R1: `b_drive` is high exactly when `en_b` is high. `a_drive` is high exactly when `en_a_n` is low.
- R2: When `sel_ab` is 0, `b_out` equals `a_in`.
- R3: When `sel_ab` is 1, `b_out` equals the contents of the A-to-B register.
- R4: When `sel_ba` is 0, `a_out` equals `b_in`. When `sel_ba` is 1, `a_out` equals the contents of the B-to-A register.
- R5: On a rising `clk_ab` edge with `rst` low, the A-to-B register loads the resolved A bus value. That value is `a_out` when `a_drive` is high and `a_in` otherwise. The load happens for every enable setting.
- R6: On a rising `clk_ba` edge with `rst` low, the B-to-A register loads the resolved B bus value. That value is `b_out` when `b_drive` is high and `b_in` otherwise.
- R7: With `en_b` = 0 and `en_a_n` = 1, neither port drives, and both registers still load from the external inputs.
- R8: With `en_b` = 1, `en_a_n` = 1 and `sel_ab` = 0, a tick of both clocks leaves `a_in` in both registers. With `en_b` = 0, `en_a_n` = 0 and `sel_ba` = 0, a tick of both clocks leaves `b_in` in both registers.
- R9: With `en_b` = 1, `en_a_n` = 0 and both selects at 1, both ports drive. Port B shows the stored A-to-B value and port A shows the stored B-to-A value.
- R10: When both ports drive and both selects are 0, `b_out` equals `a_in` and `a_out` equals `b_in`.
- R11: A rising edge of either clock with `rst` high clears that clock's register to zero.
- R12: An edge of one clock alone leaves the other direction's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock of the A-to-B register |
| clk_ba | input | 1 | Clock of the B-to-A register |
| rst | input | 1 | Synchronous clear, active high, sampled by each clock |
| a_in | input | 8 | External value on port A |
| a_out | output | 8 | Data the block presents on port A |
| a_drive | output | 1 | Output enable of port A |
| b_in | input | 8 | External value on port B |
| b_out | output | 8 | Data the block presents on port B |
| b_drive | output | 1 | Output enable of port B |
| en_b | input | 1 | Port B drive enable, active high |
| en_a_n | input | 1 | Port A drive enable, active low |
| sel_ab | input | 1 | Port B source: 0 live A input, 1 stored A-to-B register |
| sel_ba | input | 1 | Port A source: 0 live B input, 1 stored B-to-A register |

## Verification
Some checks run on every clock edge. At each edge the assertions confirm the enable decode, the live-or-stored choice on each port, and isolation. After each edge they confirm that the register holds the bus value resolved just before it, or zero under reset.

Other behaviour only appears across several steps of a scenario. The bench shows that one clock's edge leaves the other register alone. It also shows the store-in-both cases when both clocks tick together, the exchange of stored values when both ports drive, and what the registers hold after the enables change. Each of these is visible only by reading the register back later through a high select.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int XCVR_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_source_mux.sv
module xcvr_source_mux #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  import xcvr_pkg::*;
  src_e src;

  always_comb begin
    src = src_e'(sel);
    y   = (src == SRC_STORED) ? stored : live;
  end
endmodule

// File: rtl/xcvr_bus_resolve.sv
module xcvr_bus_resolve #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         drive,
  input  logic [W-1:0] own,
  input  logic [W-1:0] ext,
  output logic [W-1:0] bus
);
  // an enabled port sees its own driven value; an idle port sees the outside
  assign bus = drive ? own : ext;
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         en_b,
  input  logic         en_a_n,
  input  logic         sel_ab,
  input  logic         sel_ba
);
  logic [W-1:0] q_ab, q_ba;
  logic [W-1:0] a_bus, b_bus;

  // enables of opposite polarity
  assign b_drive = en_b;
  assign a_drive = ~en_a_n;

  // live paths take the opposite port's external input only, so no loop exists
  xcvr_source_mux #(.W(W)) u_mux_b (.sel(sel_ab), .live(a_in), .stored(q_ab), .y(b_out));
  xcvr_source_mux #(.W(W)) u_mux_a (.sel(sel_ba), .live(b_in), .stored(q_ba), .y(a_out));

  xcvr_bus_resolve #(.W(W)) u_res_a (.drive(a_drive), .own(a_out), .ext(a_in), .bus(a_bus));
  xcvr_bus_resolve #(.W(W)) u_res_b (.drive(b_drive), .own(b_out), .ext(b_in), .bus(b_bus));

  xcvr_capture_reg #(.W(W)) u_reg_ab (.clk(clk_ab), .rst(rst), .d(a_bus), .q(q_ab));
  xcvr_capture_reg #(.W(W)) u_reg_ba (.clk(clk_ba), .rst(rst), .d(b_bus), .q(q_ba));
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int W = xcvr_pkg::XCVR_W
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic         en_b,
  input logic         en_a_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);
  logic [W-1:0] seen_a, seen_b;
  assign seen_a = a_drive ? a_out : a_in;
  assign seen_b = b_drive ? b_out : b_in;

  a_r1_drive_decode: assert property (@(posedge clk_ab) disable iff (rst)
    (b_drive == en_b) && (a_drive != en_a_n));
  a_r2_live_b: assert property (@(posedge clk_ab) disable iff (rst)
    !sel_ab |-> b_out == a_in);
  a_r3_stored_b: assert property (@(posedge clk_ab) disable iff (rst)
    sel_ab |-> b_out == q_ab);
  a_r4_source_a: assert property (@(posedge clk_ba) disable iff (rst)
    a_out == (sel_ba ? q_ba : b_in));
  a_r5_capture_ab: assert property (@(posedge clk_ab) disable iff (rst)
    !rst |=> q_ab == $past(seen_a));
  a_r6_capture_ba: assert property (@(posedge clk_ba) disable iff (rst)
    !rst |=> q_ba == $past(seen_b));
  a_r7_isolation: assert property (@(posedge clk_ab) disable iff (rst)
    (!en_b && en_a_n) |-> (!a_drive && !b_drive));
  a_r9_both_stored: assert property (@(posedge clk_ba) disable iff (rst)
    (en_b && !en_a_n && sel_ab && sel_ba) |-> (a_out == q_ba && b_out == q_ab));
  a_r11_clear_ab: assert property (@(posedge clk_ab) rst |=> q_ab == '0);
  a_r11_clear_ba: assert property (@(posedge clk_ba) rst |=> q_ba == '0);
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.W(W)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
  .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
  .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
  .en_b(en_b), .en_a_n(en_a_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .q_ab(q_ab), .q_ba(q_ba)
);

// File: tb/test_dual_reg_xcvr.sv
module test_dual_reg_xcvr;
  localparam int W = 8;

  logic clk_ab = 0, clk_ba = 0, rst = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;
  logic en_b = 0, en_a_n = 1, sel_ab = 0, sel_ba = 0;

  logic [W-1:0] m_ab = '0, m_ba = '0;
  int nvec = 0, nbad = 0;
  bit done = 0;

  dual_reg_xcvr #(.W(W)) i_dual_reg_xcvr (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .en_b(en_b), .en_a_n(en_a_n), .sel_ab(sel_ab), .sel_ba(sel_ba)
  );

  function automatic logic [W-1:0] x_aout();
    return sel_ba ? m_ba : b_in;
  endfunction
  function automatic logic [W-1:0] x_bout();
    return sel_ab ? m_ab : a_in;
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // 100 MHz pulse on the clocks picked by mask (bit0 clk_ab, bit1 clk_ba)
  task automatic tick(input logic [1:0] mask);
    logic [W-1:0] na, nb;
    na = (!en_a_n) ? x_aout() : a_in;
    nb = en_b ? x_bout() : b_in;
    #5;
    clk_ab = mask[0];
    clk_ba = mask[1];
    if (mask[0]) m_ab = rst ? '0 : na;
    if (mask[1]) m_ba = rst ? '0 : nb;
    #5;
    clk_ab = 0;
    clk_ba = 0;
    #2;
  endtask

  task automatic chk_ports(string ta, string tb);
    chk("R1", {7'd0, b_drive}, {7'd0, en_b});
    chk("R1", {7'd0, a_drive}, {7'd0, ~en_a_n});
    chk(ta, a_out, x_aout());
    chk(tb, b_out, x_bout());
  endtask

  task automatic chk_store(string ta, string tb);
    logic sa, sb;
    sa = sel_ab; sb = sel_ba;
    sel_ab = 1; sel_ba = 1;
    #2;
    chk(tb, b_out, m_ab);
    chk(ta, a_out, m_ba);
    sel_ab = sa; sel_ba = sb;
    #2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    // R11: reset clears both registers
    a_in = 8'hA5; b_in = 8'h5A;
    rst = 1; tick(2'b11); rst = 0;
    chk("R11", m_ab, 8'h00);
    chk_store("R11", "R11");

    // R7: isolation, both still load the outside values
    en_b = 0; en_a_n = 1; a_in = 8'h5A; b_in = 8'hC3;
    #2;
    chk("R7", {6'd0, a_drive, b_drive}, 8'h00);
    tick(2'b11);
    chk_store("R7", "R7");
    chk("R7", m_ab, 8'h5A);

    // R12: one clock alone
    a_in = 8'h11; b_in = 8'h99;
    tick(2'b01);
    chk_store("R12", "R12");
    chk("R12", m_ba, 8'hC3);
    a_in = 8'h22; b_in = 8'h77;
    tick(2'b10);
    chk_store("R12", "R12");
    chk("R12", m_ab, 8'h11);

    // R8: A value into both registers, then B value into both
    en_b = 1; en_a_n = 1; sel_ab = 0; sel_ba = 0; a_in = 8'h96; b_in = 8'h21;
    tick(2'b11);
    chk_store("R8", "R8");
    chk("R8", m_ba, 8'h96);
    en_b = 0; en_a_n = 0; b_in = 8'h4D; a_in = 8'h30;
    tick(2'b11);
    chk_store("R8", "R8");
    chk("R8", m_ab, 8'h4D);

    // R9: both ports drive stored data
    a_in = 8'h01; b_in = 8'h02;
    tick(2'b01);
    en_b = 1; en_a_n = 0; sel_ab = 1; sel_ba = 1;
    #2;
    chk_ports("R9", "R9");
    chk("R9", {6'd0, a_drive, b_drive}, 8'h03);

    // R10: both drive, both live
    sel_ab = 0; sel_ba = 0; a_in = 8'h3C; b_in = 8'hE1;
    #2;
    chk("R10", b_out, 8'h3C);
    chk("R10", a_out, 8'hE1);

    // sweep of every enable, select and clock combination over data patterns
    for (int i = 0; i < 256; i++) begin
      en_b   = i[0];
      en_a_n = i[1];
      sel_ab = i[2];
      sel_ba = i[3];
      a_in = W'((i * 37 + 11) % 256);
      b_in = W'((i * 91 + 200) % 256);
      #2;
      chk_ports("R4", sel_ab ? "R3" : "R2");
      tick(2'(i >> 4));
      chk_ports("R4", sel_ab ? "R3" : "R2");
      chk_store("R6", "R5");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule